// File: doc/BRIEF.md
# Load-ALU Micro-Fusion Decider

This block sits after instruction decode in an out-of-order front end. Each decoded instruction may pair a memory load with an ALU operation, and for each one the block decides where that pair goes. The pair can stay packed in one fused-domain slot through issue and rename. It can also be split into two slots before issue, which is called un-lamination. The choice depends on the addressing mode of the memory operand, on whether an immediate is present, and on whether the destination register is both read and written. In both cases the load and the ALU operation reach the execution units as two separate micro-ops. The unfused-domain count therefore stays at two for any memory-plus-ALU instruction.

Up to `NUM_SLOTS` decoded instructions arrive in each cycle. For every slot the block reports, combinationally, the fused-domain slot count, the unfused-domain micro-op count and a split flag. It also registers three per-cycle totals: fused-domain slots, unfused-domain micro-ops and architectural instructions. An instruction that already absorbed a following conditional branch is marked by a branch-fused flag. That flag raises the instruction total. It never changes the load/ALU decision, because failing to micro-fuse does not prevent branch fusion.

Top module: `mfu_decider`

## Requirements
- R1: A slot whose valid bit is 0 reports 0 fused-domain slots, 0 unfused-domain micro-ops and split = 0.
- R2: A valid slot with no memory operand reports 1 fused-domain slot, 1 unfused-domain micro-op and split = 0.
- R3: A valid memory slot with mode code 0 (base register only) reports 1 fused slot, 2 unfused micro-ops and split = 0, with or without an immediate. This covers a compare of a base-addressed operand against zero. Mode code 3 is reserved and is treated as code 0.
- R4: A valid memory slot with mode code 2 (instruction-pointer relative) and an immediate reports 2 fused slots, 2 unfused micro-ops and split = 1.
- R5: A valid memory slot with mode code 2 and no immediate reports 1 fused slot, 2 unfused micro-ops and split = 0.
- R6: A valid memory slot with mode code 1 (base plus index) and no read-modify-write register destination reports 2 fused slots, 2 unfused micro-ops and split = 1.
- R7: A valid memory slot with mode code 1 and a read-modify-write register destination reports 1 fused slot, 2 unfused micro-ops and split = 0.
- R8: The branch-fused flag has no effect on a slot's fused count, unfused count or split flag.
- R9: One clock edge after a set of slot inputs is presented, `sum_fused_q` and `sum_unfused_q` hold the sums of the per-slot fused and unfused counts for that set.
- R10: One clock edge after a set of slot inputs is presented, `sum_insts_q` holds the number of architectural instructions. A valid slot counts 2 when its branch-fused flag is 1 and 1 otherwise. An invalid slot counts 0.
- R11: While `rst_n` is low at a clock edge, all three registered totals become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_valid | input | NUM_SLOTS | Slot holds a decoded instruction |
| slot_mem | input | NUM_SLOTS | Instruction has a memory load operand |
| slot_mode | input | 2*NUM_SLOTS | Addressing mode per slot: 0 base, 1 base+index, 2 IP-relative, 3 reserved |
| slot_imm | input | NUM_SLOTS | Instruction carries an immediate |
| slot_rmw | input | NUM_SLOTS | Destination register is read and written |
| slot_brfused | input | NUM_SLOTS | Instruction already fused with a following branch |
| slot_fused | output | 2*NUM_SLOTS | Per-slot fused-domain slot count |
| slot_unfused | output | 2*NUM_SLOTS | Per-slot unfused-domain micro-op count |
| slot_split | output | NUM_SLOTS | Per-slot load issued in its own slot |
| sum_fused_q | output | SUM_W | Registered total of fused-domain slots |
| sum_unfused_q | output | SUM_W | Registered total of unfused-domain micro-ops |
| sum_insts_q | output | SUM_W | Registered total of architectural instructions |

## Verification
The bench builds the block with the default of four slots. With four slots, the totals can reach their maximum of eight, which the 4-bit sum width has to hold without wrapping. Directed vectors place every addressing mode, immediate and read-modify-write combination side by side in one cycle. A full-split cycle and an all-idle cycle probe both ends of the totals. Seeded random vectors then mix slot types within a cycle, so that a slot-index or summing fault shows up in the totals.

// File: rtl/mfu_pkg.sv
package mfu_pkg;
    typedef enum logic [1:0] {
        AM_BASE = 2'd0,
        AM_IDX  = 2'd1,
        AM_RIP  = 2'd2,
        AM_RSVD = 2'd3
    } amode_e;

    localparam int CNT_W = 2;
endpackage

// File: rtl/mfu_slot_rule.sv
module mfu_slot_rule
    import mfu_pkg::*;
(
    input  logic             valid,
    input  logic             mem,
    input  logic [1:0]       mode,
    input  logic             imm,
    input  logic             rmw,
    input  logic             brfused,
    output logic [CNT_W-1:0] fused,
    output logic [CNT_W-1:0] unfused,
    output logic             split,
    output logic [CNT_W-1:0] insts
);
    amode_e am;
    logic   keep;

    always_comb begin
        am = amode_e'(mode);
        unique case (am)
            AM_IDX:  keep = rmw;
            AM_RIP:  keep = !imm;
            default: keep = 1'b1;
        endcase
    end

    always_comb begin
        fused   = '0;
        unfused = '0;
        split   = 1'b0;
        insts   = '0;
        if (valid) begin
            insts = brfused ? CNT_W'(2) : CNT_W'(1);
            if (!mem) begin
                fused   = CNT_W'(1);
                unfused = CNT_W'(1);
            end else begin
                fused   = keep ? CNT_W'(1) : CNT_W'(2);
                unfused = CNT_W'(2);
                split   = !keep;
            end
        end
    end
endmodule

// File: rtl/mfu_sum.sv
module mfu_sum #(
    parameter int N     = 4,
    parameter int IN_W  = 2,
    parameter int OUT_W = 4
) (
    input  logic [N*IN_W-1:0] vec,
    output logic [OUT_W-1:0]  total
);
    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++) begin
            total = total + OUT_W'(vec[i*IN_W +: IN_W]);
        end
    end
endmodule

// File: rtl/mfu_decider.sv
module mfu_decider
    import mfu_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int SUM_W = $clog2(2*NUM_SLOTS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SLOTS-1:0]     slot_valid,
    input  logic [NUM_SLOTS-1:0]     slot_mem,
    input  logic [2*NUM_SLOTS-1:0]   slot_mode,
    input  logic [NUM_SLOTS-1:0]     slot_imm,
    input  logic [NUM_SLOTS-1:0]     slot_rmw,
    input  logic [NUM_SLOTS-1:0]     slot_brfused,
    output logic [2*NUM_SLOTS-1:0]   slot_fused,
    output logic [2*NUM_SLOTS-1:0]   slot_unfused,
    output logic [NUM_SLOTS-1:0]     slot_split,
    output logic [SUM_W-1:0]         sum_fused_q,
    output logic [SUM_W-1:0]         sum_unfused_q,
    output logic [SUM_W-1:0]         sum_insts_q
);
    typedef struct packed {
        logic [SUM_W-1:0] fused;
        logic [SUM_W-1:0] unfused;
        logic [SUM_W-1:0] insts;
    } totals_t;

    logic [CNT_W*NUM_SLOTS-1:0] insts_vec;
    logic [SUM_W-1:0]           tot_fused, tot_unfused, tot_insts;
    totals_t                    tot_d, tot_q;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        mfu_slot_rule u_rule (
            .valid   (slot_valid[g]),
            .mem     (slot_mem[g]),
            .mode    (slot_mode[2*g +: 2]),
            .imm     (slot_imm[g]),
            .rmw     (slot_rmw[g]),
            .brfused (slot_brfused[g]),
            .fused   (slot_fused[CNT_W*g +: CNT_W]),
            .unfused (slot_unfused[CNT_W*g +: CNT_W]),
            .split   (slot_split[g]),
            .insts   (insts_vec[CNT_W*g +: CNT_W])
        );
    end

    mfu_sum #(.N(NUM_SLOTS), .IN_W(CNT_W), .OUT_W(SUM_W)) u_sum_fused (
        .vec(slot_fused), .total(tot_fused)
    );
    mfu_sum #(.N(NUM_SLOTS), .IN_W(CNT_W), .OUT_W(SUM_W)) u_sum_unfused (
        .vec(slot_unfused), .total(tot_unfused)
    );
    mfu_sum #(.N(NUM_SLOTS), .IN_W(CNT_W), .OUT_W(SUM_W)) u_sum_insts (
        .vec(insts_vec), .total(tot_insts)
    );

    always_comb begin
        tot_d = tot_q;
        if (!rst_n) begin
            tot_d = '0;
        end else begin
            tot_d.fused   = tot_fused;
            tot_d.unfused = tot_unfused;
            tot_d.insts   = tot_insts;
        end
    end

    always_ff @(posedge clk) begin
        tot_q <= tot_d;
    end

    assign sum_fused_q   = tot_q.fused;
    assign sum_unfused_q = tot_q.unfused;
    assign sum_insts_q   = tot_q.insts;
endmodule

// File: rtl/mfu_decider_chk.sv
module mfu_decider_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int SUM_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_SLOTS-1:0]   slot_valid,
    input logic [NUM_SLOTS-1:0]   slot_mem,
    input logic [2*NUM_SLOTS-1:0] slot_mode,
    input logic [NUM_SLOTS-1:0]   slot_imm,
    input logic [NUM_SLOTS-1:0]   slot_rmw,
    input logic [NUM_SLOTS-1:0]   slot_brfused,
    input logic [2*NUM_SLOTS-1:0] slot_fused,
    input logic [2*NUM_SLOTS-1:0] slot_unfused,
    input logic [NUM_SLOTS-1:0]   slot_split,
    input logic [SUM_W-1:0]       sum_fused_q,
    input logic [SUM_W-1:0]       sum_unfused_q,
    input logic [SUM_W-1:0]       sum_insts_q
);
    logic [SUM_W-1:0] chk_fused, chk_unfused;

    always_comb begin
        chk_fused   = '0;
        chk_unfused = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            chk_fused   = chk_fused + SUM_W'(slot_fused[2*i +: 2]);
            chk_unfused = chk_unfused + SUM_W'(slot_unfused[2*i +: 2]);
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (sum_fused_q == '0 && sum_unfused_q == '0 && sum_insts_q == '0)); // R11

    AST_SUM_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (sum_fused_q == $past(chk_fused) && sum_unfused_q == $past(chk_unfused))); // R9

    AST_INSTS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (sum_insts_q <= SUM_W'(2*$past($countones(slot_valid))))); // R10

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
        AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_valid[g] |-> (slot_fused[2*g +: 2] == 2'd0 && slot_unfused[2*g +: 2] == 2'd0
                                && !slot_split[g])); // R1
        AST_NOMEM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_valid[g] && !slot_mem[g]) |->
                (slot_fused[2*g +: 2] == 2'd1 && slot_unfused[2*g +: 2] == 2'd1)); // R2
        AST_RIPIMM_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_valid[g] && slot_mem[g] && slot_mode[2*g +: 2] == 2'd2 && slot_imm[g]) |->
                (slot_fused[2*g +: 2] == 2'd2 && slot_split[g])); // R4
        AST_IDX_RMW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_valid[g] && slot_mem[g] && slot_mode[2*g +: 2] == 2'd1 && slot_rmw[g]) |->
                (slot_fused[2*g +: 2] == 2'd1 && !slot_split[g])); // R7
    end
endmodule

bind mfu_decider mfu_decider_chk #(.NUM_SLOTS(NUM_SLOTS), .SUM_W(SUM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_mem(slot_mem),
    .slot_mode(slot_mode), .slot_imm(slot_imm), .slot_rmw(slot_rmw),
    .slot_brfused(slot_brfused), .slot_fused(slot_fused), .slot_unfused(slot_unfused),
    .slot_split(slot_split), .sum_fused_q(sum_fused_q), .sum_unfused_q(sum_unfused_q),
    .sum_insts_q(sum_insts_q)
);

// File: tb/mfu_decider_bench.sv
module mfu_decider_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]   v, m, im, rw, bf;
    logic [2*N-1:0] md;
    logic [2*N-1:0] o_fused, o_unfused;
    logic [N-1:0]   o_split;
    logic [SW-1:0]  s_fused, s_unfused, s_insts;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mfu_decider #(.NUM_SLOTS(N)) u_mfu_decider (
        .clk(clk), .rst_n(rst_n), .slot_valid(v), .slot_mem(m), .slot_mode(md),
        .slot_imm(im), .slot_rmw(rw), .slot_brfused(bf), .slot_fused(o_fused),
        .slot_unfused(o_unfused), .slot_split(o_split), .sum_fused_q(s_fused),
        .sum_unfused_q(s_unfused), .sum_insts_q(s_insts)
    );

    // expected per-slot values from the requirements
    function automatic int e_fused(bit vv, bit mm, bit [1:0] mo, bit ii, bit rr);
        if (!vv) return 0;
        if (!mm) return 1;
        if (mo == 2'd1) return rr ? 1 : 2;
        if (mo == 2'd2) return ii ? 2 : 1;
        return 1;
    endfunction
    function automatic int e_unfused(bit vv, bit mm);
        if (!vv) return 0;
        return mm ? 2 : 1;
    endfunction
    function automatic string tag(bit vv, bit mm, bit [1:0] mo, bit ii);
        if (!vv) return "R1";
        if (!mm) return "R2";
        if (mo == 2'd1) return "R6/R7";
        if (mo == 2'd2) return ii ? "R4" : "R5";
        return "R3";
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(bit [N-1:0] a_v, bit [N-1:0] a_m, bit [2*N-1:0] a_md,
                         bit [N-1:0] a_im, bit [N-1:0] a_rw, bit [N-1:0] a_bf);
        int ef = 0, eu = 0, ei = 0;
        @(negedge clk);
        v = a_v; m = a_m; md = a_md; im = a_im; rw = a_rw; bf = a_bf;
        #1;
        for (int i = 0; i < N; i++) begin
            int f = e_fused(a_v[i], a_m[i], a_md[2*i +: 2], a_im[i], a_rw[i]);
            int u = e_unfused(a_v[i], a_m[i]);
            string t = tag(a_v[i], a_m[i], a_md[2*i +: 2], a_im[i]);
            chk(t, int'(o_fused[2*i +: 2]), f);
            chk(t, int'(o_unfused[2*i +: 2]), u);
            chk(t, int'(o_split[i]), (f == 2) ? 1 : 0);
            ef += f; eu += u;
            ei += a_v[i] ? (a_bf[i] ? 2 : 1) : 0;
        end
        @(posedge clk);
        #1;
        chk("R9", int'(s_fused), ef);
        chk("R9", int'(s_unfused), eu);
        chk("R10", int'(s_insts), ei);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [2*N-1:0] r8_f, r8_u;
        logic [N-1:0]   r8_s;
        v = '1; m = '1; md = '1; im = '1; rw = '0; bf = '1;
        repeat (3) @(posedge clk);
        #1;
        // R11: reset clears the totals
        chk("R11", int'(s_fused), 0);
        chk("R11", int'(s_unfused), 0);
        chk("R11", int'(s_insts), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 base (incl. compare to zero imm), R5 rip no imm, R6 idx, R7 idx+rmw
        apply(4'b1111, 4'b1111, {2'd1, 2'd1, 2'd2, 2'd0}, 4'b0001, 4'b1000, 4'b0000);
        // R4 rip+imm, R3 reserved mode, R2 no mem, R1 invalid
        apply(4'b0111, 4'b0011, {2'd0, 2'd0, 2'd3, 2'd2}, 4'b0011, 4'b0000, 4'b0100);
        // all split: totals at their maximum
        apply(4'b1111, 4'b1111, {2'd1, 2'd2, 2'd1, 2'd2}, 4'b1111, 4'b0000, 4'b1111);
        // all idle
        apply(4'b0000, 4'b1111, 8'hFF, 4'b1111, 4'b1111, 4'b1111);

        // R8: the branch-fused flag changes no per-slot decision
        apply(4'b1111, 4'b1110, {2'd2, 2'd1, 2'd1, 2'd0}, 4'b1001, 4'b0010, 4'b0000);
        r8_f = o_fused; r8_u = o_unfused; r8_s = o_split;
        apply(4'b1111, 4'b1110, {2'd2, 2'd1, 2'd1, 2'd0}, 4'b1001, 4'b0010, 4'b1111);
        chk("R8", int'(o_fused), int'(r8_f));
        chk("R8", int'(o_unfused), int'(r8_u));
        chk("R8", int'(o_split), int'(r8_s));

        void'($urandom(32'd4711));
        for (int k = 0; k < 300; k++) begin
            apply(4'($urandom), 4'($urandom), 8'($urandom), 4'($urandom),
                  4'($urandom), 4'($urandom));
        end

        // R11 again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R11", int'(s_fused), 0);
        chk("R11", int'(s_insts), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule